// File: doc/BRIEF.md
# ROM Search Step Sequencer

This block carries out one decision step of the binary search that finds device identities on a single-wire bus. After a start pulse it asks an external bit-slot engine for two read slots. Each read is a slot that sends a 1, so the line can be sampled. The first read returns the identity bit and the second returns its complement. From the pair, the block picks a branch direction and asks the engine for one more slot that writes that direction.

The caller supplies the preferred direction, which is used only when the two read bits leave the choice open. The caller receives a 3-bit result and a one-cycle done pulse. The result holds bit 0 = identity bit, bit 1 = complement bit and bit 2 = direction taken. If both read bits are 1, no device answered. The block then reports code 011 at once and writes nothing. Tracking the discrepancy position across all identity bits belongs to the caller.

Top module: `rom_search_step`

## Requirements
- R1: While reset is held and in the first cycle after it, slot_req_o, done_o and busy_o are 0 and result_o is 3'b000.
- R2: After start_i is accepted, the first two slot requests carry slot_val_o = 1. These are read slots; the first returns the identity bit and the second the complement bit.
- R3: result_o packs bit 0 = identity bit, bit 1 = complement bit, bit 2 = direction taken.
- R4: When both read bits are 1, result_o becomes 3'b011 and no third slot is requested. done_o rises in the cycle after the second slot's done.
- R5: When both read bits are 0, the direction is pref_dir_i as sampled with start_i. The result is 3'b100 for direction 1 and 3'b000 for direction 0.
- R6: When exactly one read bit is 1, the direction equals the identity bit. The result is 3'b101 when the identity bit is 1 and 3'b010 when it is 0.
- R7: In every non-error case, exactly one third slot is requested, with slot_val_o equal to the direction. done_o rises in the cycle after that slot's done.
- R8: slot_req_o is a one-cycle strobe. No new request is issued until the outstanding slot reports done.
- R9: start_i is ignored while busy_o is 1. It neither restarts nor adds slots.
- R10: done_o lasts one cycle. result_o changes only together with done_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin one search step (ignored while busy) |
| pref_dir_i | input | 1 | Direction to take when both read bits are 0 |
| slot_req_o | output | 1 | One-cycle request to the bit-slot engine |
| slot_val_o | output | 1 | Bit value the requested slot sends |
| slot_done_i | input | 1 | Engine reports the outstanding slot finished |
| slot_bit_i | input | 1 | Line level sampled by the finished slot |
| busy_o | output | 1 | A step is in progress |
| done_o | output | 1 | One-cycle pulse when the result is valid |
| result_o | output | 3 | {direction, complement bit, identity bit} |

## Verification
The embedded properties check the following on every cycle:
- the strobe shape of slot_req_o and done_o;
- that read slots always send 1;
- that an error code never reports direction 1;
- that a single valid bit always sets the direction;
- that the result never moves between done pulses.

Three behaviours depend on the values the engine returns, so only the bench scenarios can show them:
- the exact slot count, including that the write slot is absent on error;
- the use of the sampled preferred direction;
- the latency from the last slot's done to done_o and the rejection of a mid-step start.

// File: rtl/rom_search_step.sv
module rom_search_step (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       pref_dir_i,
  output logic       slot_req_o,
  output logic       slot_val_o,
  input  logic       slot_done_i,
  input  logic       slot_bit_i,
  output logic       busy_o,
  output logic       done_o,
  output logic [2:0] result_o
);

  typedef enum logic [1:0] {S_IDLE, S_ID, S_CMP, S_DIR} st_t;

  st_t        st;
  logic       pref_q;
  logic       id_q;
  logic [2:0] res_q;
  logic       dir_w;

  // in S_CMP, slot_bit_i is the complement bit
  assign dir_w  = (id_q | slot_bit_i) ? id_q : pref_q;
  assign busy_o = (st != S_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      pref_q     <= 1'b0;
      id_q       <= 1'b0;
      res_q      <= 3'b000;
      result_o   <= 3'b000;
      slot_req_o <= 1'b0;
      slot_val_o <= 1'b0;
      done_o     <= 1'b0;
    end else begin
      slot_req_o <= 1'b0;
      done_o     <= 1'b0;
      case (st)
        S_IDLE: if (start_i) begin
          pref_q     <= pref_dir_i;
          slot_req_o <= 1'b1;
          slot_val_o <= 1'b1;
          st         <= S_ID;
        end
        S_ID: if (slot_done_i) begin
          id_q       <= slot_bit_i;
          slot_req_o <= 1'b1;
          slot_val_o <= 1'b1;
          st         <= S_CMP;
        end
        S_CMP: if (slot_done_i) begin
          if (id_q && slot_bit_i) begin
            result_o <= 3'b011;
            done_o   <= 1'b1;
            st       <= S_IDLE;
          end else begin
            res_q      <= {dir_w, slot_bit_i, id_q};
            slot_req_o <= 1'b1;
            slot_val_o <= dir_w;
            st         <= S_DIR;
          end
        end
        S_DIR: if (slot_done_i) begin
          result_o <= res_q;
          done_o   <= 1'b1;
          st       <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_req_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    slot_req_o |=> !slot_req_o);

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_result_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable(result_o));

  p_read_val_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_req_o && (st == S_ID || st == S_CMP)) |-> slot_val_o);

  p_err_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && result_o[1:0] == 2'b11) |-> !result_o[2]);

  p_one_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && (result_o[0] ^ result_o[1])) |-> (result_o[2] == result_o[0]));

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o) |-> !busy_o);

endmodule

// File: tb/rom_search_step_tb.sv
module rom_search_step_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0, pref_dir_i = 1'b0, slot_done_i = 1'b0, slot_bit_i = 1'b0;
  logic slot_req_o, slot_val_o, busy_o, done_o;
  logic [2:0] result_o;

  int n_checks = 0;
  int n_errs = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  rom_search_step dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .pref_dir_i(pref_dir_i),
    .slot_req_o(slot_req_o), .slot_val_o(slot_val_o), .slot_done_i(slot_done_i),
    .slot_bit_i(slot_bit_i), .busy_o(busy_o), .done_o(done_o), .result_o(result_o)
  );

  function automatic logic [2:0] exp_res(logic id, logic cmp, logic pref);
    if (id && cmp) return 3'b011;
    if (!id && !cmp) return {pref, 2'b00};
    return {id, cmp, id};
  endfunction

  task automatic chk(string req, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(logic id, logic cmp, logic pref, bit poke_start);
    logic [2:0] e;
    int slots = 0, delay = 0, iter = 0, last_resp = -10;
    bit pending = 0, got = 0;
    logic [2:0] vals = 3'b000;
    e = exp_res(id, cmp, pref);
    @(negedge clk); start_i = 1'b1; pref_dir_i = pref;
    @(negedge clk); start_i = 1'b0; pref_dir_i = ~pref;
    while (iter < 100) begin
      slot_done_i = 1'b0;
      start_i = (poke_start && slots == 1) ? 1'b1 : 1'b0;
      if (done_o) begin got = 1; break; end
      if (slot_req_o) begin
        if (slots < 3) vals[slots] = slot_val_o;
        slots++;
        pending = 1; delay = $urandom % 4;
      end else if (pending) begin
        if (delay == 0) begin
          slot_done_i = 1'b1;
          slot_bit_i = (slots == 1) ? id : (slots == 2) ? cmp : $urandom % 2;
          pending = 0; last_resp = iter;
        end else delay--;
      end
      iter++;
      @(negedge clk);
    end
    start_i = 1'b0;
    chk("R8 step completes", got, 1);
    chk("R2 first slot value", vals[0], 1);
    chk("R2 second slot value", vals[1], 1);
    chk((e == 3'b011) ? "R4 slot count" : "R7 slot count", slots, (e == 3'b011) ? 2 : 3);
    if (e != 3'b011) chk("R7 write slot value", vals[2], e[2]);
    chk((e == 3'b011) ? "R4 done latency" : "R7 done latency", iter, last_resp + 1);
    if (e == 3'b011) chk("R4 error code", result_o, 3'b011);
    else if (!id && !cmp) chk("R5 open choice result", result_o, e);
    else chk("R6 single bit result", result_o, e);
    chk("R3 encoding", result_o, e);
    if (poke_start) chk("R9 start ignored", slots, (e == 3'b011) ? 2 : 3);
    @(negedge clk);
    chk("R10 done one cycle", done_o, 0);
    chk("R10 result held", result_o, e);
    chk("R9 no request after done", slot_req_o, 0);
  endtask

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    chk("R1 req in reset", slot_req_o, 0);
    chk("R1 done in reset", done_o, 0);
    chk("R1 busy in reset", busy_o, 0);
    chk("R1 result in reset", result_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle after reset", busy_o, 0);
    for (int k = 0; k < 8; k++) step(k[0], k[1], k[2], 1'b0);
    step(1'b0, 1'b0, 1'b1, 1'b1);
    step(1'b1, 1'b1, 1'b0, 1'b1);
    for (int k = 0; k < 40; k++) step($urandom % 2, $urandom % 2, $urandom % 2, ($urandom % 4) == 0);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!finished) begin
      n_checks++; n_errs++;
      $display("FAIL watchdog R8 actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
      $finish;
    end
  end
endmodule